// File: doc/BRIEF.md
# Row-Scanned Matrix Keypad Encoder

This block reads a 4-row by 3-column switch matrix. It pulls one row line low at a time, in a fixed order. The column lines idle high through external pull-ups. A closed switch in the active row pulls its column low. The block synchronizes the raw column lines, samples them once per row, and builds one scan result per full pass over the rows.

A result has to repeat over several consecutive passes before the block reports a key. It reports the key as a code on `key_code_o` together with a one-cycle `key_valid_o` strobe. Each press is reported once. No other key is reported until the matrix has read empty for the same number of passes.

The output is a plain event strobe. It has no ready input and cannot be back-pressured, so the consumer must capture the code in the cycle the strobe is high. The code holds its value until the next report.

Top module: `keypad_scanner`

## Requirements
- R1: While reset is asserted, every row line is driven high and `key_valid_o` is low. After reset is released, the first row driven low is row 0.
- R2: Outside reset, at most one row line is low in any cycle.
- R3: Rows are driven low in the order 0, 1, 2, 3, 0, and so on. Each row stays low for DWELL cycles, and its columns are sampled in the last of those cycles. DWELL must be at least 3 to cover the two-stage synchronizer.
- R4: The reported code for the key at row r and column c is 4*r + c. The code is the row index in bits [3:2] and the column index in bits [1:0], so codes 3, 7, 11 and 15 never appear.
- R5: `key_valid_o` is high for exactly one cycle per accepted press. `key_code_o` changes only in the cycle where `key_valid_o` is high.
- R6: While any key remains held after a report, no further report is made. This holds even if the held key changes to a different key. A new report needs STABLE consecutive scan passes with no key down first.
- R7: If several columns are low in the same row, the lowest column index is reported.
- R8: If keys in different rows are down, the key in the row scanned first in a pass (lowest row index) is reported.
- R9: A key must produce the same result for STABLE consecutive scan passes before it is reported. With STABLE of at least 2, a closure shorter than one scan pass is never reported.
- R10: A held key is reported no later than (STABLE+1)*ROWS*DWELL + 4 cycles after it closes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| col_n_i | input | COLS (3) | Raw column lines, low when a key in the driven row is closed |
| row_n_o | output | ROWS (4) | Active-low row drive |
| key_code_o | output | 4 | Code of the last reported key |
| key_valid_o | output | 1 | One-cycle strobe marking a new report |

## Verification
A scan pass lasts ROWS*DWELL cycles. A row's columns are sampled DWELL-1 cycles after the row goes low, through two synchronizer flops. The strobe follows the sample of the last row by two registers.

The row drive is checked every cycle against a position computed from the cycle count since reset release. A press can land at any phase of the scan, so each key check does not wait on a fixed cycle. Instead it opens a window of (STABLE+2) passes after the stimulus, counts the strobes seen in that window, and compares the cycle of the first strobe against the R10 bound. Release windows of the same length confirm that no strobe appears, and that the matrix is re-armed before the next press.

// File: rtl/kpd_pkg.sv
package kpd_pkg;
  // Number of flops between the raw column pins and the sampling logic.
  localparam int KPD_SYNC_STAGES = 2;
  // Smallest row dwell that still samples settled, synchronized columns.
  localparam int KPD_MIN_DWELL   = KPD_SYNC_STAGES + 1;
endpackage

// File: rtl/kpd_sync.sv
module kpd_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '1;
        else if (s == 0) stage_q[s] <= d_i;
        else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/kpd_row_scan.sv
module kpd_row_scan #(
  parameter  int ROWS  = 4,
  parameter  int DWELL = 4,
  localparam int RW    = $clog2(ROWS),
  localparam int DW    = $clog2(DWELL)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [ROWS-1:0] row_n_o,
  output logic [RW-1:0] row_idx_o,
  output logic          sample_o,
  output logic          last_row_o
);
  logic          run_q;
  logic [RW-1:0] row_q;
  logic [DW-1:0] dwell_q;
  logic          dwell_end;

  assign dwell_end = (dwell_q == DW'(DWELL-1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      row_q   <= '0;
      dwell_q <= '0;
    end else begin
      run_q <= 1'b1;
      if (run_q) begin
        if (dwell_end) begin
          dwell_q <= '0;
          row_q   <= (row_q == RW'(ROWS-1)) ? '0 : row_q + 1'b1;
        end else begin
          dwell_q <= dwell_q + 1'b1;
        end
      end
    end
  end

  generate
    for (genvar r = 0; r < ROWS; r++) begin : g_row
      assign row_n_o[r] = !(run_q && (row_q == RW'(r)));
    end
  endgenerate

  assign row_idx_o  = row_q;
  assign sample_o   = run_q && dwell_end;
  assign last_row_o = sample_o && (row_q == RW'(ROWS-1));
endmodule

// File: rtl/kpd_frame_eval.sv
module kpd_frame_eval #(
  parameter  int ROWS   = 4,
  parameter  int COLS   = 3,
  localparam int RW     = $clog2(ROWS),
  localparam int CLW    = $clog2(COLS),
  localparam int CODE_W = RW + CLW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample_i,
  input  logic              last_row_i,
  input  logic [RW-1:0]     row_idx_i,
  input  logic [COLS-1:0]   col_s_i,
  output logic              done_o,
  output logic              hit_o,
  output logic [CODE_W-1:0] code_o
);
  logic              row_hit;
  logic [CLW-1:0]    low_col;
  logic [CODE_W-1:0] row_code;
  logic              acc_hit_q;
  logic [CODE_W-1:0] acc_code_q;

  // Lowest-numbered low column wins inside one row.
  always_comb begin
    row_hit = 1'b0;
    low_col = '0;
    for (int c = COLS-1; c >= 0; c--) begin
      if (!col_s_i[c]) begin
        row_hit = 1'b1;
        low_col = CLW'(c);
      end
    end
  end

  assign row_code = {row_idx_i, low_col};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_hit_q  <= 1'b0;
      acc_code_q <= '0;
      done_o     <= 1'b0;
      hit_o      <= 1'b0;
      code_o     <= '0;
    end else begin
      done_o <= 1'b0;
      if (sample_i) begin
        if (last_row_i) begin
          done_o    <= 1'b1;
          hit_o     <= acc_hit_q | row_hit;
          code_o    <= acc_hit_q ? acc_code_q : row_code;
          acc_hit_q <= 1'b0;
        end else if (row_hit && !acc_hit_q) begin
          acc_hit_q  <= 1'b1;
          acc_code_q <= row_code;
        end
      end
    end
  end
endmodule

// File: rtl/kpd_debounce.sv
module kpd_debounce #(
  parameter  int CODE_W = 4,
  parameter  int STABLE = 2,
  localparam int NW     = $clog2(STABLE + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              done_i,
  input  logic              hit_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              key_valid_o,
  output logic [CODE_W-1:0] key_code_o
);
  localparam logic [NW-1:0] STABLE_N = NW'(STABLE);

  logic              prev_hit_q;
  logic [CODE_W-1:0] prev_code_q;
  logic [NW-1:0]     run_len_q;
  logic [NW-1:0]     run_len_d;
  logic              armed_q;
  logic              same;

  assign same = (hit_i == prev_hit_q) && (!hit_i || (code_i == prev_code_q));

  always_comb begin
    if (!same)                       run_len_d = NW'(1);
    else if (run_len_q == STABLE_N)  run_len_d = run_len_q;
    else                             run_len_d = run_len_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_hit_q  <= 1'b0;
      prev_code_q <= '0;
      run_len_q   <= '0;
      armed_q     <= 1'b1;
      key_valid_o <= 1'b0;
      key_code_o  <= '0;
    end else begin
      key_valid_o <= 1'b0;
      if (done_i) begin
        prev_hit_q  <= hit_i;
        prev_code_q <= code_i;
        run_len_q   <= run_len_d;
        if (run_len_d == STABLE_N) begin
          if (hit_i && armed_q) begin
            key_valid_o <= 1'b1;
            key_code_o  <= code_i;
            armed_q     <= 1'b0;
          end else if (!hit_i) begin
            armed_q <= 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/keypad_scanner.sv
module keypad_scanner #(
  parameter  int ROWS   = 4,
  parameter  int COLS   = 3,
  parameter  int DWELL  = 4,
  parameter  int STABLE = 2,
  localparam int RW     = $clog2(ROWS),
  localparam int CODE_W = RW + $clog2(COLS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [COLS-1:0]   col_n_i,
  output logic [ROWS-1:0]   row_n_o,
  output logic [CODE_W-1:0] key_code_o,
  output logic              key_valid_o
);
  logic [COLS-1:0]   col_s;
  logic [RW-1:0]     row_idx;
  logic              sample;
  logic              last_row;
  logic              frame_done;
  logic              frame_hit;
  logic [CODE_W-1:0] frame_code;

  kpd_sync #(.W(COLS), .STAGES(kpd_pkg::KPD_SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .d_i(col_n_i), .q_o(col_s)
  );

  kpd_row_scan #(.ROWS(ROWS), .DWELL(DWELL)) scan_i (
    .clk(clk), .rst_n(rst_n), .row_n_o(row_n_o), .row_idx_o(row_idx),
    .sample_o(sample), .last_row_o(last_row)
  );

  kpd_frame_eval #(.ROWS(ROWS), .COLS(COLS)) eval_i (
    .clk(clk), .rst_n(rst_n), .sample_i(sample), .last_row_i(last_row),
    .row_idx_i(row_idx), .col_s_i(col_s), .done_o(frame_done),
    .hit_o(frame_hit), .code_o(frame_code)
  );

  kpd_debounce #(.CODE_W(CODE_W), .STABLE(STABLE)) deb_i (
    .clk(clk), .rst_n(rst_n), .done_i(frame_done), .hit_i(frame_hit),
    .code_i(frame_code), .key_valid_o(key_valid_o), .key_code_o(key_code_o)
  );
endmodule

// File: rtl/kpd_scan_checker.sv
module kpd_scan_checker #(
  parameter int ROWS   = 4,
  parameter int COLS   = 3,
  parameter int CODE_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ROWS-1:0]   row_n,
  input logic [CODE_W-1:0] key_code,
  input logic              key_valid
);
  localparam int CLW = $clog2(COLS);

  // R1: idle rows and quiet strobe during reset
  a_r1_reset_idle: assert property (@(posedge clk)
    !rst_n |-> (&row_n && !key_valid));

  // R2: never more than one row pulled low
  a_r2_single_row: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~row_n));

  // R3: the active row only ever advances to the next one
  a_r3_row_order: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(row_n) && !(&$past(row_n)))
      |-> (row_n == {$past(row_n[ROWS-2:0]), $past(row_n[ROWS-1])}));

  // R5: strobe lasts a single cycle
  a_r5_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    key_valid |=> !key_valid);

  // R5: code moves only together with the strobe
  a_r5_code_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !key_valid |-> $stable(key_code));

  // R4: reported column field is a real column
  a_r4_code_range: assert property (@(posedge clk) disable iff (!rst_n)
    key_valid |-> (key_code[CLW-1:0] < CLW'(COLS)));
endmodule

bind keypad_scanner kpd_scan_checker #(.ROWS(ROWS), .COLS(COLS), .CODE_W(CODE_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .row_n(row_n_o), .key_code(key_code_o),
  .key_valid(key_valid_o)
);

// File: tb/keypad_scanner_tb_top.sv
module keypad_scanner_tb_top;
  localparam int ROWS   = 4;
  localparam int COLS   = 3;
  localparam int DWELL  = 4;
  localparam int STABLE = 2;
  localparam int FRAME  = ROWS * DWELL;
  localparam int WIN    = (STABLE + 2) * FRAME;
  localparam int LAT    = (STABLE + 1) * FRAME + 4;
  localparam int NKEY   = ROWS * COLS;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [COLS-1:0] col_n;
  logic [ROWS-1:0] row_n;
  logic [3:0]      key_code;
  logic            key_valid;
  logic [NKEY-1:0] pressed = '0;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  int pulses = 0;
  int first_cyc = -1;
  int first_code = -1;
  bit finished = 0;

  always #2 clk = ~clk;

  keypad_scanner #(.ROWS(ROWS), .COLS(COLS), .DWELL(DWELL), .STABLE(STABLE)) dut_i (
    .clk(clk), .rst_n(rst_n), .col_n_i(col_n), .row_n_o(row_n),
    .key_code_o(key_code), .key_valid_o(key_valid)
  );

  // Switch matrix: a closed key ties its column to its row when that row is low.
  always_comb begin
    for (int c = 0; c < COLS; c++) begin
      col_n[c] = 1'b1;
      for (int r = 0; r < ROWS; r++)
        if (pressed[r*COLS+c] && !row_n[r]) col_n[c] = 1'b0;
    end
  end

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (key_valid) begin
      if (pulses == 0) begin
        first_cyc  = cyc;
        first_code = int'(key_code);
      end
      pulses = pulses + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clear_mon();
    pulses = 0;
    first_cyc = -1;
    first_code = -1;
  endtask

  // Apply a key mask, watch one window, compare strobe count and code.
  task automatic press(input logic [NKEY-1:0] mask, input int exp_n, input int exp_code,
                       input string tag);
    int t0;
    @(negedge clk);
    clear_mon();
    pressed = mask;
    t0 = cyc;
    repeat (WIN) @(negedge clk);
    #1;
    chk(pulses == exp_n, {tag, " strobe count"}, pulses, exp_n);
    if (exp_n > 0) begin
      chk(first_code == exp_code, {tag, " code"}, first_code, exp_code);
      chk((first_cyc - t0) <= LAT, "R10 latency", first_cyc - t0, LAT);
    end
  endtask

  task automatic release_all(input string tag);
    @(negedge clk);
    clear_mon();
    pressed = '0;
    repeat (WIN) @(negedge clk);
    #1;
    chk(pulses == 0, {tag, " no strobe on release"}, pulses, 0);
  endtask

  function automatic logic [NKEY-1:0] key(input int r, input int c);
    return NKEY'(1) << (r*COLS + c);
  endfunction

  initial begin
    int exp_row;
    int low_cnt;
    int low_idx;
    repeat (3) @(negedge clk);
    chk(&row_n, "R1 rows high in reset", int'(row_n), (1<<ROWS)-1);
    chk(!key_valid, "R1 strobe low in reset", int'(key_valid), 0);
    rst_n = 1'b1;
    chk(&row_n, "R1 rows high before first edge", int'(row_n), (1<<ROWS)-1);

    // R2/R3: walk two passes and compare against the cycle count.
    for (int k = 1; k <= 2*FRAME; k++) begin
      @(negedge clk);
      exp_row = ((k-1) / DWELL) % ROWS;
      low_cnt = 0;
      low_idx = -1;
      for (int r = 0; r < ROWS; r++) if (!row_n[r]) begin low_cnt++; low_idx = r; end
      chk(low_cnt == 1, "R2 single low row", low_cnt, 1);
      chk(low_idx == exp_row, "R3 row position", low_idx, exp_row);
    end

    // R4/R5: every key alone, code 4*row+col.
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) begin
        press(key(r, c), 1, r*4 + c, "R4 R5 single key");
        release_all("R6");
      end

    // R6: held key is not repeated.
    press(key(2, 1), 1, 9, "R6 hold");
    press(key(2, 1), 0, 0, "R6 still held");
    // R6: switching keys without a clean release is not reported.
    press(key(0, 2), 0, 0, "R6 swap while held");
    release_all("R6");
    press(key(1, 0), 1, 4, "R6 rearmed");
    release_all("R6");

    // R7: two columns in one row, lowest column wins.
    press(key(3, 1) | key(3, 2), 1, 13, "R7 lowest column");
    release_all("R7");
    press(key(1, 0) | key(1, 2), 1, 4, "R7 lowest column");
    release_all("R7");

    // R8: keys in several rows, earliest scanned row wins.
    press(key(1, 2) | key(3, 0), 1, 6, "R8 first row");
    release_all("R8");
    press(key(0, 1) | key(2, 0) | key(3, 2), 1, 1, "R8 first row");
    release_all("R8");

    // R9: closure shorter than one pass is rejected.
    for (int n = 0; n < 3; n++) begin
      @(negedge clk);
      clear_mon();
      pressed = key(n, n);
      repeat (FRAME/2) @(negedge clk);
      pressed = '0;
      repeat (WIN) @(negedge clk);
      #1;
      chk(pulses == 0, "R9 short closure ignored", pulses, 0);
    end
    press(key(3, 0), 1, 12, "R9 full press after bounce");
    release_all("R9");

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #400000;
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule